// File: doc/BRIEF.md
# Trailing-Edge PWM with Phase-Locked Sample Strobe

This block drives the switches of a PWM digital-to-analog converter whose filtered output is captured by a sample-and-hold stage. It produces two waveforms that share one period from a single free-running counter. The first is a PWM whose falling edge is fixed at the counter wrap and whose rising edge moves with the duty word. The second is a half-period strobe that goes high on the same clock on which the PWM drops. The hold stage can therefore latch the integrator at a fixed phase, whatever the duty value.

A new duty word is captured on a load strobe into a shadow register. It takes effect at the next counter wrap, so no period ever mixes two duty values. Each waveform can be inverted by a parameter to suit the select sense of the analog switch. A one-clock period-start pulse marks the first count of every period. The period is 2^CNT_W clocks. It is 65536 clocks with the default width.

Top module: `pwm_sh_top`

## Requirements
- R1: The period is exactly 2^CNT_W enabled clocks. `per_o` is high for one clock per period, on the clock where the counter shows 0, and is low on every other count.
- R2: With applied duty d, the PWM level is high exactly when the count is at least 2^CNT_W - d. It is high for d clocks in one contiguous run that ends at the last count, and it is low at count 0. d = 0 keeps it low all period. d = all ones keeps it high on every count except 0.
- R3: The PWM level falls only on a clock where `per_o` is high.
- R4: The strobe level is high for counts 0 to 2^(CNT_W-1)-1 and low for the upper half, for every duty value, including duties above half. It is high whenever `per_o` is high, and it rises only together with `per_o` while enable stays high.
- R5: `load_i` captures `duty_i` into a shadow register. The shadow value becomes the applied duty only at the counter wrap. A load during a period leaves that period unchanged. A load on the terminal-count clock applies to the period that starts on the next clock.
- R6: When the parameter PWM_INV or STB_INV is 1, the matching output is the complement of its level at every instant, including the inactive level.
- R7: While `en_i` is low, the counter holds its value and the PWM level, the strobe level and `per_o` are all low. When `en_i` returns high, counting resumes from the held count.
- R8: `rst_ni` asserts asynchronously and is released synchronously through two flops. Reset sets the counter to its terminal count, clears the shadow and applied duty, and drives all outputs to their inactive levels. With enable high, `per_o` first appears on the third clock after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable; when low the counter holds and outputs are inactive |
| duty_i | input | CNT_W | Duty word: number of high clocks per period |
| load_i | input | 1 | Captures duty_i into the shadow register |
| pwm_o | output | 1 | Trailing-edge PWM, inverted if PWM_INV |
| stb_o | output | 1 | Half-period sample strobe, inverted if STB_INV |
| per_o | output | 1 | One-clock pulse at count 0 |

## Verification
Several relations are checked on every clock: a PWM fall always coincides with the period pulse, a strobe rise after steady enable does too, the period pulse appears only at count 0, the PWM is never high at count 0, and a disabled clock freezes the count and silences all outputs. The bench scenarios cover what needs a whole period to observe. These are the exact high-time and rising-edge position for each duty, the full-period strobe shape, and that a load in mid-period does not disturb the current period. They also cover a load on the terminal clock, the resume position after a pause, the reset-release latency, and the inverted variant.

// File: rtl/pwm_sh_pkg.sv
package pwm_sh_pkg;

  // Raw (non-inverted) output levels, registered together.
  typedef struct packed {
    logic pwm;
    logic stb;
    logic per;
  } wave_t;

  localparam wave_t WAVE_IDLE = '{pwm: 1'b0, stb: 1'b0, per: 1'b0};

endpackage

// File: rtl/pwm_sh_cnt.sv
module pwm_sh_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_n,
  output logic         wrap_n
);

  localparam logic [W-1:0] TERM = {W{1'b1}};

  always_comb begin
    cnt_n  = en ? cnt_q + 1'b1 : cnt_q;
    wrap_n = en && (cnt_q == TERM);
  end

  // Reset parks the counter at terminal count so the first enabled clock
  // opens a clean period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TERM;
    end else if (en) begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/pwm_sh_duty.sv
module pwm_sh_duty #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] duty_in,
  input  logic         wrap_n,
  output logic [W-1:0] act_n
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] shadow_n;
  logic [W-1:0] act_q;

  always_comb begin
    shadow_n = load ? duty_in : shadow_q;
    act_n    = wrap_n ? shadow_n : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (load) begin
      shadow_q <= duty_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (wrap_n) begin
      act_q <= shadow_n;
    end
  end

endmodule

// File: rtl/pwm_sh_wave.sv
module pwm_sh_wave
  import pwm_sh_pkg::*;
#(
  parameter int W       = 16,
  parameter bit PWM_INV = 1'b0,
  parameter bit STB_INV = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cnt_n,
  input  logic [W-1:0] act_n,
  input  logic         wrap_n,
  output logic         pwm_o,
  output logic         stb_o,
  output logic         per_o
);

  localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

  logic [W:0] thr;
  wave_t      lvl_n;
  wave_t      lvl_q;

  always_comb begin
    thr   = FULL - {1'b0, act_n};
    lvl_n = WAVE_IDLE;
    if (en) begin
      lvl_n.pwm = ({1'b0, cnt_n} >= thr);
      lvl_n.stb = ~cnt_n[W-1];
      lvl_n.per = wrap_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= WAVE_IDLE;
    end else begin
      lvl_q <= lvl_n;
    end
  end

  generate
    if (PWM_INV) begin : g_pwm_inv
      assign pwm_o = ~lvl_q.pwm;
    end else begin : g_pwm_dir
      assign pwm_o = lvl_q.pwm;
    end
    if (STB_INV) begin : g_stb_inv
      assign stb_o = ~lvl_q.stb;
    end else begin : g_stb_dir
      assign stb_o = lvl_q.stb;
    end
  endgenerate

  assign per_o = lvl_q.per;

endmodule

// File: rtl/pwm_sh_top.sv
module pwm_sh_top #(
  parameter int CNT_W   = 16,
  parameter bit PWM_INV = 1'b0,
  parameter bit STB_INV = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             load_i,
  output logic             pwm_o,
  output logic             stb_o,
  output logic             per_o
);

  logic             rst_q1;
  logic             rst_q2;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             wrap_n;
  logic [CNT_W-1:0] act_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  pwm_sh_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk_i),
    .rst_n  (rst_q2),
    .en     (en_i),
    .cnt_q  (cnt_q),
    .cnt_n  (cnt_n),
    .wrap_n (wrap_n)
  );

  pwm_sh_duty #(.W(CNT_W)) u_duty (
    .clk     (clk_i),
    .rst_n   (rst_q2),
    .load    (load_i),
    .duty_in (duty_i),
    .wrap_n  (wrap_n),
    .act_n   (act_n)
  );

  pwm_sh_wave #(.W(CNT_W), .PWM_INV(PWM_INV), .STB_INV(STB_INV)) u_wave (
    .clk    (clk_i),
    .rst_n  (rst_q2),
    .en     (en_i),
    .cnt_n  (cnt_n),
    .act_n  (act_n),
    .wrap_n (wrap_n),
    .pwm_o  (pwm_o),
    .stb_o  (stb_o),
    .per_o  (per_o)
  );

endmodule

// File: rtl/pwm_sh_chk.sv
module pwm_sh_chk #(
  parameter int W       = 16,
  parameter bit PWM_INV = 1'b0,
  parameter bit STB_INV = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         pwm,
  input logic         stb,
  input logic         per,
  input logic [W-1:0] cnt
);

  logic pwm_l;
  logic stb_l;
  logic en_q1;
  logic en_q2;

  assign pwm_l = pwm ^ PWM_INV;
  assign stb_l = stb ^ STB_INV;

  // Enable as seen by the previous two register updates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q1 <= 1'b0;
      en_q2 <= 1'b0;
    end else begin
      en_q1 <= en;
      en_q2 <= en_q1;
    end
  end

  assert_pwm_fall_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q1 && $fell(pwm_l)) |-> per);

  assert_stb_rise_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q1 && en_q2 && $rose(stb_l)) |-> per);

  assert_stb_high_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per |-> stb_l);

  assert_pulse_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    per |-> (cnt == '0));

  assert_pwm_low_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_l |-> (cnt != '0));

  assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q1 |-> (!pwm_l && !stb_l && !per));

  assert_hold_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q1 |-> $stable(cnt));

endmodule

bind pwm_sh_top pwm_sh_chk #(
  .W       (CNT_W),
  .PWM_INV (PWM_INV),
  .STB_INV (STB_INV)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_q2),
  .en    (en_i),
  .pwm   (pwm_o),
  .stb   (stb_o),
  .per   (per_o),
  .cnt   (cnt_q)
);

// File: tb/tb_pwm_sh_top.sv
module tb_pwm_sh_top;

  localparam int W    = 6;
  localparam int N    = 1 << W;
  localparam int NVEC = 6;

  // Vector table: duty written, expected high clocks, expected first high count.
  localparam int VEC_DUTY  [NVEC] = '{0, 1, 16, 32, 48, 63};
  localparam int VEC_HIGH  [NVEC] = '{0, 1, 16, 32, 48, 63};
  localparam int VEC_FIRST [NVEC] = '{64, 63, 48, 32, 16, 1};

  logic         clk;
  logic         rst_n;
  logic         en;
  logic [W-1:0] duty;
  logic         load;
  logic         pwm, stb, per;
  logic         pwm_i, stb_i, per_i;

  int checks = 0;
  int errors = 0;

  pwm_sh_top #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .duty_i(duty), .load_i(load),
    .pwm_o(pwm), .stb_o(stb), .per_o(per)
  );

  pwm_sh_top #(.CNT_W(W), .PWM_INV(1'b1), .STB_INV(1'b1)) dut_inv (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .duty_i(duty), .load_i(load),
    .pwm_o(pwm_i), .stb_o(stb_i), .per_o(per_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_per();
    do @(negedge clk); while (!per);
  endtask

  // Starts on a sample where per is high; ends on the next such sample.
  task automatic measure(input int exp_hi, input int first, input int load_idx, input int load_val);
    int hi = 0, bad_pwm = 0, bad_stb = 0, bad_per = 0, bad_inv = 0;
    for (int i = 0; i < N; i++) begin
      if (pwm) hi++;
      if (pwm !== (i >= first)) bad_pwm++;
      if (stb !== (i < N / 2)) bad_stb++;
      if (per !== (i == 0)) bad_per++;
      if ((pwm_i !== ~pwm) || (stb_i !== ~stb) || (per_i !== per)) bad_inv++;
      if (i == load_idx) begin
        load = 1'b1;
        duty = load_val[W-1:0];
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    load = 1'b0;
    chk("R2", "high clocks", hi, exp_hi);
    chk("R2", "pwm shape mismatches", bad_pwm, 0);
    chk("R4", "strobe shape mismatches", bad_stb, 0);
    chk("R1", "period pulse misplaced", bad_per, 0);
    chk("R1", "pulse after full period", int'(per), 1);
    chk("R6", "inverted instance mismatches", bad_inv, 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    en    = 1'b0;
    load  = 1'b0;
    duty  = '0;
    repeat (3) @(negedge clk);
    // R8: inactive levels during reset
    chk("R8", "pwm in reset", int'(pwm), 0);
    chk("R8", "stb in reset", int'(stb), 0);
    chk("R8", "per in reset", int'(per), 0);
    chk("R6", "inverted pwm in reset", int'(pwm_i), 1);
    chk("R6", "inverted stb in reset", int'(stb_i), 1);

    en    = 1'b1;
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!per && n < 10);
    chk("R8", "clocks to first pulse", n, 3);

    // Table walk: load at a period start, measure the following period.
    for (int v = 0; v < NVEC; v++) begin
      load = 1'b1;
      duty = VEC_DUTY[v][W-1:0];
      @(negedge clk);
      load = 1'b0;
      wait_per();
      measure(VEC_HIGH[v], VEC_FIRST[v], -1, 0);
    end

    // R5: mid-period load leaves current period alone, applies at the wrap.
    load = 1'b1;
    duty = 6'd16;
    @(negedge clk);
    load = 1'b0;
    wait_per();
    measure(16, 48, N / 4, 48);
    measure(48, 16, -1, 0);

    // R5: load on terminal count applies to the period starting next clock.
    measure(48, 16, N - 1, 8);
    measure(8, 56, -1, 0);

    // R7: pause at count 5, outputs inactive, counter holds.
    repeat (5) @(negedge clk);
    en = 1'b0;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pwm || stb || per || !pwm_i || !stb_i) n++;
    end
    chk("R7", "active outputs while disabled", n, 0);
    en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!per && n < 2 * N);
    chk("R7", "clocks to pulse after resume", n, N - 5);
    measure(8, 56, -1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule